// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves one virtual address after a translation miss. It takes a request carrying a 32-bit virtual address and an access type. It forms the address of one page table entry from a writable table base and the virtual page number. It reads that entry over a simple memory read port whose latency may vary, and then reports one of three outcomes: a physical address, a page fault, or a protection violation.

The virtual address is split into a 20-bit page number (bits 31:12) and a 12-bit offset (bits 11:0), giving 4 KB pages. Entries are 32 bits wide and are fetched with a 4-byte stride. The offset passes straight into the physical address, and the entry supplies the upper 20 bits. The walker serves one request at a time. It refuses new work from the moment it accepts a request until the cycle in which it presents the response.

Top module: `ptw_top`

## Requirements
- R1: After a synchronous reset, req_ready is 1, rsp_valid is 0, mem_req_valid is 0, and the table base is 0.
- R2: The entry address issued on mem_req_addr equals base + 4 × vaddr[31:12], modulo 2^32. The base used is the value held when the request is accepted, and a write through base_we affects the walks accepted after it.
- R3: While mem_req_valid is high and mem_req_ready is low, the request stays asserted with an unchanged address.
- R4: The walker produces a response only after a mem_rsp_valid that arrives after its read was accepted. A mem_rsp_valid pulse while no read is outstanding has no effect on any output.
- R5: If entry bit 31 (valid) is 0, rsp_status is 1 (page fault) and rsp_paddr is 0, whatever the rights field holds.
- R6: The rights field is entry bits 21:20: 0 none, 1 read-only, 2 read/write, 3 execute-only. The access type is 0 read, 1 write, 2 fetch, 3 reserved. Read-only allows read. Read/write allows read and write. Execute-only allows fetch. Nothing else is allowed, and the reserved type is never allowed. A valid entry whose rights do not allow the access gives rsp_status 2 (protection violation) and rsp_paddr 0.
- R7: A valid, permitted entry gives rsp_status 0 and rsp_paddr = {entry[19:0], vaddr[11:0]}. Entry bits 30:22 are ignored.
- R8: req_ready is 0 from the cycle after acceptance until the walk completes. rsp_valid is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Write strobe for the table base |
| base_wdata | input | 32 | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 protection violation |
| rsp_paddr | output | 32 | Physical address, 0 on any fault |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents |

## Verification
The hardest conditions to create from the ports are a response strobe from memory that arrives while the read request is still being stalled, and one that arrives while the walker is idle. A port-accurate memory model in the bench can stall acceptance for a chosen number of cycles. During the stall it can inject a bogus all-zero entry, which would read as a page fault if it were taken. It can also fire a lone response pulse while the walker is idle. The full matrix of valid bit, rights code and access type is swept under two table bases, with varied latency, and the results are compared against outcomes computed arithmetically in the bench.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PPN_W     = 20;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int PTE_W     = 32;
    localparam int PTE_BYTES = PTE_W / 8;
    localparam int PTE_SHIFT = $clog2(PTE_BYTES);
    localparam int PTE_V_BIT = 31;
    localparam int PTE_R_LSB = 20;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RGT_NONE = 2'd0,
        RGT_RO   = 2'd1,
        RGT_RW   = 2'd2,
        RGT_EXEC = 2'd3
    } rights_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_PGF   = 2'd1,
        ST_PROT  = 2'd2,
        ST_UNUSE = 2'd3
    } status_e;

    typedef struct packed {
        logic             valid;
        rights_e          rights;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    function automatic pte_t pte_decode(input logic [PTE_W-1:0] raw);
        pte_t p;
        p.valid  = raw[PTE_V_BIT];
        p.rights = rights_e'(raw[PTE_R_LSB+1:PTE_R_LSB]);
        p.ppn    = raw[PPN_W-1:0];
        return p;
    endfunction

    function automatic logic rights_allow(input rights_e r, input acc_e a);
        logic ok;
        case (r)
            RGT_RO:   ok = (a == ACC_READ);
            RGT_RW:   ok = (a == ACC_READ) || (a == ACC_WRITE);
            RGT_EXEC: ok = (a == ACC_FETCH);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/ptw_check.sv
module ptw_check
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw,
    input  acc_e             acc,
    input  logic [OFF_W-1:0] off,
    output status_e          status,
    output logic [PA_W-1:0]  paddr
);
    pte_t pte;

    always_comb begin
        pte = pte_decode(raw);
        if (!pte.valid) begin
            status = ST_PGF;
            paddr  = '0;
        end else if (!rights_allow(pte.rights, acc)) begin
            status = ST_PROT;
            paddr  = '0;
        end else begin
            status = ST_OK;
            paddr  = {pte.ppn, off};
        end
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic mem_req_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic capture,
    output logic rsp_valid
);
    typedef enum logic [1:0] {S_IDLE, S_READ, S_WAIT, S_RESP} state_e;
    state_e st_q, st_d;

    always_comb begin
        st_d          = st_q;
        req_ready     = (st_q == S_IDLE);
        mem_req_valid = (st_q == S_READ);
        rsp_valid     = (st_q == S_RESP);
        accept        = req_ready && req_valid;
        capture       = (st_q == S_WAIT) && mem_rsp_valid;
        case (st_q)
            S_IDLE: if (req_valid)     st_d = S_READ;
            S_READ: if (mem_req_ready) st_d = S_WAIT;
            S_WAIT: if (mem_rsp_valid) st_d = S_RESP;
            S_RESP:                    st_d = S_IDLE;
            default:                   st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_IDLE;
        else     st_q <= st_d;
    end

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_rsp_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(mem_rsp_valid));
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    logic [ADDR_W-1:0] base_q;
    logic              accept, capture;
    vaddr_t            va_in;
    logic [OFF_W-1:0]  off_q;
    acc_e              acc_q;
    logic [ADDR_W-1:0] addr_q;
    status_e           chk_status, st_q;
    logic [PA_W-1:0]   chk_paddr, pa_q;

    assign va_in = vaddr_t'(req_vaddr);

    ptw_base_reg #(.W(ADDR_W)) u_base (
        .clk(clk), .rst(rst), .we(base_we), .wdata(base_wdata), .q(base_q)
    );

    ptw_fsm u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .accept(accept),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .capture(capture), .rsp_valid(rsp_valid)
    );

    ptw_check u_check (
        .raw(mem_rsp_data), .acc(acc_q), .off(off_q),
        .status(chk_status), .paddr(chk_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            acc_q  <= ACC_READ;
            addr_q <= '0;
            st_q   <= ST_OK;
            pa_q   <= '0;
        end else begin
            if (accept) begin
                off_q  <= va_in.off;
                acc_q  <= acc_e'(req_acc);
                addr_q <= base_q + (ADDR_W'(va_in.vpn) << PTE_SHIFT);
            end
            if (capture) begin
                st_q <= chk_status;
                pa_q <= chk_paddr;
            end
        end
    end

    assign mem_req_addr = addr_q;
    assign rsp_status   = st_q;
    assign rsp_paddr    = pa_q;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != ST_OK) |-> (rsp_paddr == '0));

    assert_ok_offset_R7: assert property (@(posedge clk) disable iff (rst)
        (accept ##1 1'b1) |-> (off_q == $past(req_vaddr[OFF_W-1:0])));
endmodule

// File: tb/test_ptw_top.sv
module test_ptw_top;
    import ptw_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        base_we;
    logic [31:0] base_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_acc;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    always #5 clk = ~clk;

    ptw_top i_ptw_top (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int fails  = 0;

    // memory model controls
    int          m_lat   = 0;
    int          m_stall = 0;
    bit          m_spur  = 0;
    bit          m_idle_pulse = 0;
    bit          tb_v    = 0;
    logic [1:0]  tb_r    = 0;
    logic [31:0] seen_addr = 0;
    logic [31:0] stall_addr = 0;
    bit          stalling = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] ppn_of(input logic [31:0] a);
        return a[21:2] ^ 20'h5A5A5;
    endfunction

    // memory responder, acting at falling edges only
    initial begin
        bit busy;
        int cnt;
        busy = 0; cnt = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            mem_req_ready = 0;
            mem_rsp_valid = 0;
            if (busy) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = {tb_v, 9'h1FF, tb_r, ppn_of(seen_addr)};
                    busy = 0;
                end else cnt--;
            end else if (mem_req_valid) begin
                if (!stalling) begin
                    stalling   = 1;
                    stall_addr = mem_req_addr;
                end else begin
                    check("R3 address stable while stalled", mem_req_addr, stall_addr);
                end
                if (m_stall > 0) begin
                    m_stall--;
                    if (m_spur) begin
                        mem_rsp_valid = 1;
                        mem_rsp_data  = 32'h0;
                    end
                end else begin
                    mem_req_ready = 1;
                    seen_addr = mem_req_addr;
                    busy = 1;
                    cnt = m_lat;
                    stalling = 0;
                end
            end else if (m_idle_pulse) begin
                m_idle_pulse  = 0;
                mem_rsp_valid = 1;
                mem_rsp_data  = 32'h8000_0000;
            end
        end
    end

    task automatic print_summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        print_summary();
        $finish;
    end

    task automatic write_base(input logic [31:0] b);
        @(negedge clk);
        base_we = 1; base_wdata = b;
        @(negedge clk);
        base_we = 0;
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base,
                        input bit v, input logic [1:0] r, input int lat, input int stall, input bit spur);
        logic [31:0] exp_addr, exp_pa;
        logic [1:0]  exp_st;
        bit          allow;
        int          n;
        tb_v = v; tb_r = r; m_lat = lat; m_stall = stall; m_spur = spur;
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        check("R8 req_ready low during walk", {31'b0, req_ready}, 32'd0);
        n = 0;
        while (!rsp_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        exp_addr = base + {va[31:12], 2'b00};
        allow = (r == 2'd1 && acc == 2'd0) ||
                (r == 2'd2 && (acc == 2'd0 || acc == 2'd1)) ||
                (r == 2'd3 && acc == 2'd2);
        if (!v)         begin exp_st = 2'd1; exp_pa = 32'h0; end
        else if (!allow) begin exp_st = 2'd2; exp_pa = 32'h0; end
        else            begin exp_st = 2'd0; exp_pa = {ppn_of(exp_addr), va[11:0]}; end
        check("R4 response arrives", {31'b0, rsp_valid}, 32'd1);
        check("R2 entry address", seen_addr, exp_addr);
        if (!v) begin
            check("R5 page fault status", {30'b0, rsp_status}, {30'b0, exp_st});
            check("R5 page fault paddr", rsp_paddr, exp_pa);
        end else if (!allow) begin
            check("R6 protection status", {30'b0, rsp_status}, {30'b0, exp_st});
            check("R6 protection paddr", rsp_paddr, exp_pa);
        end else begin
            check("R7 ok status", {30'b0, rsp_status}, {30'b0, exp_st});
            check("R7 ok paddr", rsp_paddr, exp_pa);
        end
        @(negedge clk);
        check("R8 rsp_valid single pulse", {31'b0, rsp_valid}, 32'd0);
        check("R8 ready again", {31'b0, req_ready}, 32'd1);
    endtask

    initial begin
        logic [31:0] base;
        rst = 1; base_we = 0; base_wdata = 0;
        req_valid = 0; req_vaddr = 0; req_acc = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 req_ready after reset", {31'b0, req_ready}, 32'd1);
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        check("R1 mem_req_valid after reset", {31'b0, mem_req_valid}, 32'd0);

        // R1: base is zero after reset, seen through the first entry address
        walk(32'h1234_5678, 2'd0, 32'h0, 1, 2'd2, 0, 0, 0);

        for (int pass = 0; pass < 2; pass++) begin
            base = (pass == 0) ? 32'h0000_0000 : 32'h8003_4000;
            if (pass == 1) write_base(base);
            for (int v = 0; v < 2; v++)
                for (int r = 0; r < 4; r++)
                    for (int a = 0; a < 4; a++) begin
                        int idx;
                        logic [31:0] va;
                        idx = pass * 32 + v * 16 + r * 4 + a;
                        va  = (idx * 32'h0135_7A13) ^ 32'hC0DE_0F0F;
                        walk(va, 2'(a), base, v[0], 2'(r), (r + a) % 4, a % 3, (r == 1) || (v == 1 && a == 2));
                    end
        end

        // R2: wrap-around of base plus maximum page number
        write_base(32'hFFC0_0004);
        walk(32'hFFFF_FFFF, 2'd2, 32'hFFC0_0004, 1, 2'd3, 2, 2, 1);
        walk(32'h0000_0ABC, 2'd1, 32'hFFC0_0004, 1, 2'd2, 0, 0, 0);

        // R4: lone response pulse while idle is ignored
        m_idle_pulse = 1;
        repeat (4) begin
            @(negedge clk);
            check("R4 no response from idle pulse", {31'b0, rsp_valid}, 32'd0);
            check("R4 still idle after idle pulse", {31'b0, req_ready}, 32'd1);
        end
        walk(32'h0765_4321, 2'd0, 32'hFFC0_0004, 1, 2'd1, 1, 1, 1);

        print_summary();
        $finish;
    end
endmodule